// File: doc/BRIEF.md
# Signed Decimal Text to Two's-Complement Converter

This block turns a short signed decimal number, held as a field of character bytes plus one sign byte, into a fixed-width two's-complement value. The character field is right-aligned. Byte 0 is the last digit typed and carries the units. Positions that were never filled hold 0x00, and those positions add nothing to the value.

A one-cycle start pulse, taken while the block reports ready, captures the whole field and the sign. The block then folds in one digit per cycle, starting at the most significant position. A final stage limits the magnitude to the output range and applies the sign. A one-cycle done pulse marks the cycle in which the new result appears. The result then stays on the output until the next conversion finishes.

Because the inputs are captured when start is taken, the register that supplies them may be cleared on the very next cycle.

Top module: `dec2bin_conv`

## Requirements
- R1: During and after synchronous reset, with no start taken, `ready_o` is 1, `done_o` is 0 and `value_o` is 0.
- R2: A start taken while `ready_o` is 1 drops `ready_o` in the next cycle. `done_o` and `ready_o` go high at the DIGITS+1-th rising edge after the edge that sampled start. With the default of four digits, that is the fifth edge.
- R3: `done_o` is high for exactly one cycle per conversion.
- R4: Byte k of `chars_i` (bits 8k+7:8k) has weight 10^k. The magnitude is the weighted sum of the digit values.
- R5: A byte in 0x30..0x39 counts as the digit it encodes. Any other byte, including 0x00, counts as zero.
- R6: A sign byte of 0x2D ('-') gives the two's-complement negation of the magnitude. Any other sign byte, including 0x2B ('+'), gives a non-negative result.
- R7: A non-negative magnitude above 2^(OUT_W-1)-1 gives 2^(OUT_W-1)-1. With the default 12-bit output, that is 2047.
- R8: A negative magnitude of 2^(OUT_W-1) or more gives the most negative value. With the default 12-bit output, that is 0x800.
- R9: `chars_i` and `sign_i` are sampled only on the edge that takes start. Changing them later does not affect the result.
- R10: A start pulse while `ready_o` is 0 is ignored. It changes neither the result nor the timing, and it produces no extra `done_o`.
- R11: `value_o` changes only at the edge that raises `done_o`.
- R12: A start pulse in the same cycle that `done_o` is high is accepted as a new conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle request to convert |
| chars_i | input | DIGITS*8 | Digit bytes; byte 0 is the units |
| sign_i | input | 8 | Sign character byte |
| ready_o | output | 1 | Converter idle, start will be taken |
| done_o | output | 1 | One-cycle pulse: new result on value_o |
| value_o | output | OUT_W | Signed two's-complement result |

## Verification
Two events can fall in the same cycle: the done pulse of one conversion and the start of the next. The bench raises start in exactly the cycle where it observes done high, with different characters. It then checks three things. Done must fall the next cycle. Ready must drop. The second result must arrive at the full conversion latency counted from that shared cycle, while the first result stays on the output in between.

A start pulse during a busy conversion is also provoked. It must leave both the first result and its timing untouched.

// File: rtl/dec2bin_pkg.sv
package dec2bin_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } conv_state_t;

  localparam logic [7:0] CH_ZERO  = 8'h30;
  localparam logic [7:0] CH_NINE  = 8'h39;
  localparam logic [7:0] CH_MINUS = 8'h2D;

  // Digit value of a character byte; anything outside '0'..'9' counts as zero.
  function automatic logic [3:0] char_digit(input logic [7:0] b);
    if (b >= CH_ZERO && b <= CH_NINE) return b[3:0];
    return 4'd0;
  endfunction

endpackage

// File: rtl/d2b_snap.sv
module d2b_snap #(
  parameter int DIGITS = 4,
  parameter int CHAR_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load_i,
  input  logic [DIGITS*CHAR_W-1:0] chars_i,
  input  logic [CHAR_W-1:0]        sign_i,
  output logic [DIGITS*CHAR_W-1:0] chars_q,
  output logic [CHAR_W-1:0]        sign_q
);

  genvar g;
  generate
    for (g = 0; g < DIGITS; g++) begin : g_pos
      always_ff @(posedge clk) begin
        if (rst)         chars_q[g*CHAR_W +: CHAR_W] <= '0;
        else if (load_i) chars_q[g*CHAR_W +: CHAR_W] <= chars_i[g*CHAR_W +: CHAR_W];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)         sign_q <= '0;
    else if (load_i) sign_q <= sign_i;
  end

  AST_SNAP_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> ($stable(chars_q) && $stable(sign_q))); // R9

endmodule

// File: rtl/d2b_mac.sv
module d2b_mac #(
  parameter int CHAR_W = 8,
  parameter int ACC_W  = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              step_i,
  input  logic [CHAR_W-1:0] byte_i,
  output logic [ACC_W-1:0]  acc_o
);
  import dec2bin_pkg::*;

  logic [3:0]       dval;
  logic [ACC_W-1:0] acc_times10;

  always_comb begin
    dval        = char_digit(byte_i[7:0]);
    acc_times10 = (acc_o << 3) + (acc_o << 1);
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) acc_o <= '0;
    else if (step_i)  acc_o <= acc_times10 + ACC_W'(dval);
  end

endmodule

// File: rtl/d2b_sat.sv
module d2b_sat #(
  parameter int ACC_W = 14,
  parameter int OUT_W = 12
) (
  input  logic [ACC_W-1:0] mag_i,
  input  logic             neg_i,
  output logic [OUT_W-1:0] res_o
);
  localparam int CMP_W = ((ACC_W > OUT_W) ? ACC_W : OUT_W) + 1;
  localparam logic [CMP_W-1:0] POS_LIM = CMP_W'((64'd1 << (OUT_W-1)) - 64'd1);
  localparam logic [CMP_W-1:0] NEG_LIM = CMP_W'(64'd1 << (OUT_W-1));

  logic [CMP_W-1:0] mag_ext, lim, clipped, negated;

  always_comb begin
    mag_ext = CMP_W'(mag_i);
    lim     = neg_i ? NEG_LIM : POS_LIM;
    clipped = (mag_ext > lim) ? lim : mag_ext;
    negated = '0 - clipped;
    res_o   = neg_i ? negated[OUT_W-1:0] : clipped[OUT_W-1:0];
  end

endmodule

// File: rtl/dec2bin_conv.sv
module dec2bin_conv #(
  parameter int DIGITS = 4,
  parameter int CHAR_W = 8,
  parameter int OUT_W  = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start_i,
  input  logic [DIGITS*CHAR_W-1:0] chars_i,
  input  logic [CHAR_W-1:0]        sign_i,
  output logic                     ready_o,
  output logic                     done_o,
  output logic [OUT_W-1:0]         value_o
);
  import dec2bin_pkg::*;

  localparam int ACC_W = $clog2(10**DIGITS);
  localparam int CNT_W = (DIGITS > 1) ? $clog2(DIGITS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIGITS-1);

  conv_state_t state_q, state_n;
  logic [CNT_W-1:0]         cnt_q;
  logic                     load, step;
  logic [DIGITS*CHAR_W-1:0] snap_chars;
  logic [CHAR_W-1:0]        snap_sign;
  logic [CHAR_W-1:0]        cur_byte;
  logic [ACC_W-1:0]         acc;
  logic [OUT_W-1:0]         sat_res;

  always_comb begin
    state_n = state_q;
    load    = 1'b0;
    step    = 1'b0;
    case (state_q)
      ST_IDLE: if (start_i) begin
        load    = 1'b1;
        state_n = ST_RUN;
      end
      ST_RUN: begin
        step = 1'b1;
        if (cnt_q == CNT_LAST) state_n = ST_FIN;
      end
      ST_FIN:  state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_comb cur_byte = snap_chars[(DIGITS-1-int'(cnt_q))*CHAR_W +: CHAR_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ready_o <= 1'b1;
      done_o  <= 1'b0;
      value_o <= '0;
    end else begin
      state_q <= state_n;
      ready_o <= (state_n == ST_IDLE);
      done_o  <= (state_q == ST_FIN);
      if (load)      cnt_q <= '0;
      else if (step) cnt_q <= cnt_q + 1'b1;
      if (state_q == ST_FIN) value_o <= sat_res;
    end
  end

  d2b_snap #(.DIGITS(DIGITS), .CHAR_W(CHAR_W)) u_snap (
    .clk(clk), .rst(rst), .load_i(load), .chars_i(chars_i), .sign_i(sign_i),
    .chars_q(snap_chars), .sign_q(snap_sign)
  );

  d2b_mac #(.CHAR_W(CHAR_W), .ACC_W(ACC_W)) u_mac (
    .clk(clk), .rst(rst), .clr_i(load), .step_i(step), .byte_i(cur_byte), .acc_o(acc)
  );

  d2b_sat #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_sat (
    .mag_i(acc), .neg_i(snap_sign == CH_MINUS), .res_o(sat_res)
  );

  AST_READY_DROP: assert property (@(posedge clk) disable iff (rst)
    (start_i && ready_o) |=> !ready_o); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R3
  AST_VALUE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(value_o)); // R11
  AST_DONE_READY: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ready_o); // R12
  AST_BUSY_NO_DONE: assert property (@(posedge clk) disable iff (rst)
    (!ready_o && !done_o) |=> !(ready_o && !done_o)); // R10

endmodule

// File: tb/sim_dec2bin_conv.sv
module sim_dec2bin_conv;
  localparam int CLK_PERIOD = 10;
  localparam int DIGITS = 4;
  localparam int OUT_W  = 12;
  localparam int LAT    = DIGITS + 2; // negedges from driving start to seeing done

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [DIGITS*8-1:0] chars = '0;
  logic [7:0] sign = 8'h2B;
  logic ready, done;
  logic [OUT_W-1:0] value;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dec2bin_conv #(.DIGITS(DIGITS), .CHAR_W(8), .OUT_W(OUT_W)) u0 (
    .clk(clk), .rst(rst), .start_i(start), .chars_i(chars), .sign_i(sign),
    .ready_o(ready), .done_o(done), .value_o(value)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, what, act, act, exp, exp);
    end
  endtask

  task automatic launch(input logic [31:0] c, input logic [7:0] s);
    @(negedge clk);
    chars = c; sign = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    lat = 1;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic conv(input logic [31:0] c, input logic [7:0] s, input int exp, input string tag);
    int lat;
    launch(c, s);
    chk(ready == 1'b0, "R2", "ready after start", int'(ready), 0);
    wait_done(lat);
    chk(lat == LAT, "R2", "latency", lat, LAT);
    chk(value == OUT_W'(exp), tag, "value", int'(value), exp & 12'hFFF);
    @(negedge clk);
    chk(done == 1'b0, "R3", "done width", int'(done), 0);
  endtask

  task automatic t_reset;
    chk(ready == 1'b1 && done == 1'b0 && value == '0, "R1", "reset state",
        int'({ready, done, value}), int'({1'b1, 1'b0, 12'h000}));
  endtask

  task automatic t_snapshot; // R9
    int lat;
    launch("1111", 8'h2B);
    chars = "9999"; sign = 8'h2D;
    wait_done(lat);
    chk(value == 12'd1111, "R9", "snapshot value", int'(value), 1111);
  endtask

  task automatic t_busy; // R10
    int lat;
    launch("0321", 8'h2B);
    chars = "0777"; sign = 8'h2D; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 2;
    while (!done && lat < 40) begin @(negedge clk); lat++; end
    chk(lat == LAT, "R10", "latency with extra start", lat, LAT);
    chk(value == 12'd321, "R10", "value with extra start", int'(value), 321);
    for (int i = 0; i < LAT + 2; i++) begin
      @(negedge clk);
      chk(done == 1'b0, "R10", "no extra done", int'(done), 0);
    end
  endtask

  task automatic t_hold; // R11
    logic [OUT_W-1:0] held;
    held = value;
    chars = "8888"; sign = 8'h2B;
    for (int i = 0; i < 8; i++) @(negedge clk);
    chk(value == held, "R11", "value held", int'(value), int'(held));
  endtask

  task automatic t_back2back; // R12
    int lat;
    launch("0055", 8'h2B);
    wait_done(lat);
    chk(value == 12'd55, "R12", "first value", int'(value), 55);
    chars = "0066"; sign = 8'h2D; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0 && ready == 1'b0, "R12", "accepted in done cycle",
        int'({done, ready}), 0);
    chk(value == 12'd55, "R12", "old value kept", int'(value), 55);
    wait_done(lat);
    chk(lat == LAT, "R12", "second latency", lat, LAT);
    chk(value == OUT_W'(-66), "R12", "second value", int'(value), (-66) & 12'hFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    conv("1234", 8'h2B, 1234, "R4");
    conv({8'h00, 8'h00, "42"}, 8'h2D, -42, "R5");
    conv({8'h00, 8'h00, 8'h00, 8'h00}, 8'h2B, 0, "R5");
    conv("A5A7", 8'h2B, 507, "R5");
    conv({8'h00, 8'h00, 8'h00, 8'h00}, 8'h2D, 0, "R6");
    conv("0987", 8'h2D, -987, "R6");
    conv("0987", 8'h20, 987, "R6");
    conv("2047", 8'h2B, 2047, "R7");
    conv("2048", 8'h2B, 2047, "R7");
    conv("9999", 8'h2B, 2047, "R7");
    conv("2047", 8'h2D, -2047, "R8");
    conv("2048", 8'h2D, -2048, "R8");
    conv("2049", 8'h2D, -2048, "R8");
    conv("9999", 8'h2D, -2048, "R8");
    t_snapshot();
    t_busy();
    t_hold();
    t_back2back();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule